// File: doc/BRIEF.md
# Host Controller Command Register

This block is the 32-bit command register of a USB 2.0-style host controller. Software reaches it through a plain write port with a combinational readback bus. The stored fields drive the rest of the controller: a run request, a self-clearing controller-reset indication, the frame-list size code, the two schedule enables, the async-advance doorbell, the park-mode fields and the 8-bit interrupt-rate threshold.

The register also sequences stopping. Once software clears the run bit, the block waits until the transaction engine reports idle and then raises `halted`. If the engine never reports idle, `halted` is forced after `HALT_UFRAMES` microframe ticks. A controller reset requested by software runs for a fixed number of clock cycles. During that time the reset bit reads 1, every other field is held at its reset value, and software writes cannot end the sequence early. Two capability parameters choose whether the frame-list size and the park fields are writable or read as constant 0.

Top module: `hc_command_reg`

## Requirements
- R1: After `rstN` is released, with both capabilities present, `rdData` reads 32'h0000_0B00, with park count 3 in bits 9:8 and park enable 1 in bit 11. `halted` is 1 and `runOut`, `ctrlResetOut`, `periodicEn`, `asyncEn` and `doorbellOut` are 0.
- R2: Bits 3:2 hold the frame-list size code: 0 selects 1024 entries, 1 selects 512 and 2 selects 256. A write carrying code 3 leaves the stored code unchanged.
- R3: Park count (bits 9:8) and park enable (bit 11) are writable. A write with park count 0 keeps the previous count. Bits 7, 10, 15:12 and 31:24 always read 0.
- R4: Writing 1 to run (bit 0) takes effect only while `halted` is 1. While the controller is stopping (run 0, `halted` 0), such a write leaves run at 0.
- R5: `halted` falls exactly one clock cycle after `runOut` rises.
- R6: After run is cleared, `halted` rises on the clock edge following the first cycle in which `engineIdle` is 1.
- R7: While stopping without `engineIdle`, `halted` rises on the edge after the 16th `uframeTick` pulse counted since run was cleared. It stays 0 after 15 pulses.
- R8: Writing 1 to bit 1 sets `ctrlResetOut` and bit 1 for exactly `RESET_CYCLES` cycles, forces every other field to its reset value with `halted` 1, and ignores all writes, including 0s, until the sequence ends.
- R9: Writing 1 to the doorbell (bit 6) sets `doorbellOut`. Writing 0 there has no effect, and a pulse on `doorbellAck` clears it.
- R10: Bits 23:16 store the interrupt threshold as written and drive `irqThreshold`. Bit 4 drives `periodicEn` and bit 5 drives `asyncEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Register readback |
| uframeTick | input | 1 | One pulse per 125 µs microframe |
| engineIdle | input | 1 | Transaction engine has no work in flight |
| doorbellAck | input | 1 | Engine has served the doorbell |
| runOut | output | 1 | Schedule execution request |
| ctrlResetOut | output | 1 | Controller reset sequence active |
| halted | output | 1 | Controller has stopped |
| frameListSize | output | 2 | Frame-list size code |
| periodicEn | output | 1 | Periodic schedule enable |
| asyncEn | output | 1 | Asynchronous schedule enable |
| doorbellOut | output | 1 | Async-advance doorbell pending |
| parkCount | output | 2 | Park-mode transaction count |
| parkEnable | output | 1 | Park mode enable |
| irqThreshold | output | 8 | Interrupt rate threshold in microframes |

## Verification
A vector table writes field patterns and checks the readback. The patterns include valid frame-list codes, the reserved code 3, a park count of 0 and ones in every reserved bit. Together they separate correct field decode from stuck, shifted or unguarded bits. Directed sequences then try stopping in two ways, by an engine-idle report and by the tick limit, with samples at 15 and 16 ticks. A run request issued mid-stop tells an ignored request apart from an accepted one. The reset sequence is timed cycle by cycle while a zero write is issued against it, which separates a self-clearing bit from one that software can cut short.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;
  localparam int RUN_BIT  = 0;
  localparam int RST_BIT  = 1;
  localparam int FLS_LO   = 2;
  localparam int PSE_BIT  = 4;
  localparam int ASE_BIT  = 5;
  localparam int BELL_BIT = 6;
  localparam int PCNT_LO  = 8;
  localparam int PEN_BIT  = 11;
  localparam int THR_LO   = 16;
  localparam int THR_W    = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic fieldWe;
    logic loadDefaults;
    logic runSet;
    logic runClr;
  } cmdStrobes_t;

  typedef struct packed {
    logic             run;
    logic [1:0]       fls;
    logic             pse;
    logic             ase;
    logic             bell;
    logic [1:0]       parkCnt;
    logic             parkEn;
    logic [THR_W-1:0] thr;
  } cmdFields_t;
endpackage

// File: rtl/hc_cmd_ctrl.sv
module hc_cmd_ctrl
  import hc_cmd_pkg::*;
#(
  parameter int RESET_CYCLES = 8,
  parameter int HALT_UFRAMES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrRun,
  input  logic        wrReset,
  input  logic        runQ,
  input  logic        uframeTick,
  input  logic        engineIdle,
  output cmdStrobes_t strobes,
  output logic        halted,
  output logic        resetBusy
);
  localparam int RW = $clog2(RESET_CYCLES + 1);
  localparam int TW = $clog2(HALT_UFRAMES + 1);
  localparam logic [RW-1:0] RST_LAST  = RW'(RESET_CYCLES - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(HALT_UFRAMES);

  logic [RW-1:0] rstCnt;
  logic [TW-1:0] tickCnt;
  logic          resetReq;

  assign resetReq = wrEn && wrReset && !resetBusy;

  always_comb begin
    strobes.loadDefaults = resetReq || resetBusy;
    strobes.fieldWe      = wrEn && !strobes.loadDefaults;
    strobes.runSet       = strobes.fieldWe && wrRun && halted;
    strobes.runClr       = strobes.fieldWe && !wrRun;
  end

  // self-clearing reset sequence of fixed length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetBusy <= 1'b0;
      rstCnt    <= '0;
    end else if (resetReq) begin
      resetBusy <= 1'b1;
      rstCnt    <= '0;
    end else if (resetBusy) begin
      if (rstCnt == RST_LAST) begin
        resetBusy <= 1'b0;
        rstCnt    <= '0;
      end else begin
        rstCnt <= rstCnt + 1'b1;
      end
    end
  end

  // halt handshake with microframe bound
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halted  <= 1'b1;
      tickCnt <= '0;
    end else if (strobes.loadDefaults) begin
      halted  <= 1'b1;
      tickCnt <= '0;
    end else if (runQ) begin
      halted  <= 1'b0;
      tickCnt <= '0;
    end else if (!halted) begin
      if (engineIdle || tickCnt == TICK_LAST) begin
        halted  <= 1'b1;
        tickCnt <= '0;
      end else if (uframeTick) begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hc_cmd_data.sv
module hc_cmd_data
  import hc_cmd_pkg::*;
#(
  parameter bit FRAME_LIST_PROG = 1'b1,
  parameter bit PARK_CAP        = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  cmdStrobes_t strobes,
  input  logic [31:0] wrData,
  input  logic        doorbellAck,
  output cmdFields_t  fields
);
  localparam logic [1:0] PCNT_RST = PARK_CAP ? 2'd3 : 2'd0;
  localparam logic       PEN_RST  = PARK_CAP;

  logic             runQ, pseQ, aseQ, bellQ, parkEnQ;
  logic [1:0]       flsQ, parkCntQ;
  logic [THR_W-1:0] thrQ;
  logic             unusedWrBits;

  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      pseQ  <= 1'b0;
      aseQ  <= 1'b0;
      bellQ <= 1'b0;
      thrQ  <= '0;
    end else if (strobes.loadDefaults) begin
      runQ  <= 1'b0;
      pseQ  <= 1'b0;
      aseQ  <= 1'b0;
      bellQ <= 1'b0;
      thrQ  <= '0;
    end else begin
      if (strobes.runSet)      runQ <= 1'b1;
      else if (strobes.runClr) runQ <= 1'b0;
      bellQ <= (bellQ && !doorbellAck) || (strobes.fieldWe && wrData[BELL_BIT]);
      if (strobes.fieldWe) begin
        pseQ <= wrData[PSE_BIT];
        aseQ <= wrData[ASE_BIT];
        thrQ <= wrData[THR_LO +: THR_W];
      end
    end
  end

  generate
    if (FRAME_LIST_PROG) begin : g_flsRw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                     flsQ <= 2'd0;
        else if (strobes.loadDefaults) flsQ <= 2'd0;
        else if (strobes.fieldWe && wrData[FLS_LO +: 2] != 2'd3)
          flsQ <= wrData[FLS_LO +: 2];
      end
    end else begin : g_flsRo
      assign flsQ = 2'd0;
    end

    if (PARK_CAP) begin : g_parkRw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          parkCntQ <= PCNT_RST;
          parkEnQ  <= PEN_RST;
        end else if (strobes.loadDefaults) begin
          parkCntQ <= PCNT_RST;
          parkEnQ  <= PEN_RST;
        end else if (strobes.fieldWe) begin
          parkEnQ <= wrData[PEN_BIT];
          if (wrData[PCNT_LO +: 2] != 2'd0) parkCntQ <= wrData[PCNT_LO +: 2];
        end
      end
    end else begin : g_parkRo
      assign parkCntQ = 2'd0;
      assign parkEnQ  = 1'b0;
    end
  endgenerate

  always_comb begin
    fields.run     = runQ;
    fields.fls     = flsQ;
    fields.pse     = pseQ;
    fields.ase     = aseQ;
    fields.bell    = bellQ;
    fields.parkCnt = parkCntQ;
    fields.parkEn  = parkEnQ;
    fields.thr     = thrQ;
  end
endmodule

// File: rtl/hc_command_reg.sv
module hc_command_reg
  import hc_cmd_pkg::*;
#(
  parameter bit FRAME_LIST_PROG = 1'b1,
  parameter bit PARK_CAP        = 1'b1,
  parameter int RESET_CYCLES    = 8,
  parameter int HALT_UFRAMES    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        uframeTick,
  input  logic        engineIdle,
  input  logic        doorbellAck,
  output logic        runOut,
  output logic        ctrlResetOut,
  output logic        halted,
  output logic [1:0]  frameListSize,
  output logic        periodicEn,
  output logic        asyncEn,
  output logic        doorbellOut,
  output logic [1:0]  parkCount,
  output logic        parkEnable,
  output logic [7:0]  irqThreshold
);
  cmdStrobes_t strobes;
  cmdFields_t  fields;
  logic        resetBusy;

  hc_cmd_ctrl #(
    .RESET_CYCLES(RESET_CYCLES),
    .HALT_UFRAMES(HALT_UFRAMES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrRun     (wrData[RUN_BIT]),
    .wrReset   (wrData[RST_BIT]),
    .runQ      (fields.run),
    .uframeTick(uframeTick),
    .engineIdle(engineIdle),
    .strobes   (strobes),
    .halted    (halted),
    .resetBusy (resetBusy)
  );

  hc_cmd_data #(
    .FRAME_LIST_PROG(FRAME_LIST_PROG),
    .PARK_CAP       (PARK_CAP)
  ) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .doorbellAck(doorbellAck),
    .fields     (fields)
  );

  always_comb begin
    rdData                     = '0;
    rdData[RUN_BIT]            = fields.run;
    rdData[RST_BIT]            = resetBusy;
    rdData[FLS_LO +: 2]        = fields.fls;
    rdData[PSE_BIT]            = fields.pse;
    rdData[ASE_BIT]            = fields.ase;
    rdData[BELL_BIT]           = fields.bell;
    rdData[PCNT_LO +: 2]       = fields.parkCnt;
    rdData[PEN_BIT]            = fields.parkEn;
    rdData[THR_LO +: THR_W]    = fields.thr;
  end

  assign runOut        = fields.run;
  assign ctrlResetOut  = resetBusy;
  assign frameListSize = fields.fls;
  assign periodicEn    = fields.pse;
  assign asyncEn       = fields.ase;
  assign doorbellOut   = fields.bell;
  assign parkCount     = fields.parkCnt;
  assign parkEnable    = fields.parkEn;
  assign irqThreshold  = fields.thr;
endmodule

// File: rtl/hc_command_reg_chk.sv
module hc_command_reg_chk #(
  parameter int RESET_CYCLES = 8,
  parameter int HALT_UFRAMES = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic        uframeTick,
  input logic        doorbellAck,
  input logic        runOut,
  input logic        ctrlResetOut,
  input logic        halted,
  input logic        periodicEn,
  input logic        asyncEn,
  input logic        doorbellOut
);
  logic [15:0] stopTicks;
  logic [15:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stopTicks <= '0;
    else if (runOut || halted) stopTicks <= '0;
    else if (uframeTick) stopTicks <= stopTicks + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= '0;
    else if (ctrlResetOut) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  // R5
  halt_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runOut && halted && !(wrEn && wrData[1])) |=> !halted);

  // R4
  run_while_stopping_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runOut && !halted) |=> !runOut);

  // R7
  halt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runOut && !halted) |-> (stopTicks <= 16'(HALT_UFRAMES)));

  // R8
  reset_defaults_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlResetOut |-> (!runOut && halted && !periodicEn && !asyncEn && !doorbellOut));

  // R8
  reset_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlResetOut) |-> (busyLen == 16'(RESET_CYCLES)));

  // R9
  doorbell_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doorbellAck && !(wrEn && wrData[6])) |=> !doorbellOut);
endmodule

bind hc_command_reg hc_command_reg_chk #(
  .RESET_CYCLES(RESET_CYCLES),
  .HALT_UFRAMES(HALT_UFRAMES)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .uframeTick  (uframeTick),
  .doorbellAck (doorbellAck),
  .runOut      (runOut),
  .ctrlResetOut(ctrlResetOut),
  .halted      (halted),
  .periodicEn  (periodicEn),
  .asyncEn     (asyncEn),
  .doorbellOut (doorbellOut)
);

// File: tb/test_hc_command_reg.sv
module test_hc_command_reg;
  localparam int RESET_CYCLES = 8;
  localparam int HALT_UFRAMES = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        uframeTick = 1'b0;
  logic        engineIdle = 1'b0;
  logic        doorbellAck = 1'b0;
  logic        runOut, ctrlResetOut, halted, periodicEn, asyncEn, doorbellOut, parkEnable;
  logic [1:0]  frameListSize, parkCount;
  logic [7:0]  irqThreshold;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hc_command_reg #(
    .FRAME_LIST_PROG(1'b1),
    .PARK_CAP       (1'b1),
    .RESET_CYCLES   (RESET_CYCLES),
    .HALT_UFRAMES   (HALT_UFRAMES)
  ) i_hc_command_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .uframeTick(uframeTick), .engineIdle(engineIdle), .doorbellAck(doorbellAck),
    .runOut(runOut), .ctrlResetOut(ctrlResetOut), .halted(halted),
    .frameListSize(frameListSize), .periodicEn(periodicEn), .asyncEn(asyncEn),
    .doorbellOut(doorbellOut), .parkCount(parkCount), .parkEnable(parkEnable),
    .irqThreshold(irqThreshold)
  );

  // {write value, expected readback}
  localparam logic [63:0] VECS [0:4] = '{
    {32'h0000_0B14, 32'h0000_0B14},  // fls 1, periodic on
    {32'h0008_0328, 32'h0008_0328},  // fls 2, async on, thr 8, park en off
    {32'h0040_090C, 32'h0040_0908},  // fls 3 reserved: keeps 2
    {32'h0000_0800, 32'h0000_0900},  // park count 0: keeps 1
    {32'hFF00_F480, 32'h0000_0100}   // reserved bits read 0
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic tickPulse();
    @(negedge clk);
    uframeTick = 1'b1;
    @(negedge clk);
    uframeTick = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", rdData, 32'h0000_0B00);
    check("R1 halted", {31'd0, halted}, 32'd1);
    check("R1 outputs", {26'd0, runOut, ctrlResetOut, periodicEn, asyncEn, doorbellOut, 1'b0}, 32'd0);

    // R2 R3 R10 field table
    for (int i = 0; i < 5; i++) begin
      writeReg(VECS[i][63:32]);
      check("R2/R3/R10 readback", rdData, VECS[i][31:0]);
    end
    writeReg(32'h0033_0B18);
    check("R10 irqThreshold", {24'd0, irqThreshold}, 32'h33);
    check("R10 periodicEn", {31'd0, periodicEn}, 32'd1);
    check("R2 frameListSize 256", {30'd0, frameListSize}, 32'd2);

    // R5 run start, halted drops one cycle later
    writeReg(32'h0000_0001);
    check("R5 run set", {31'd0, runOut}, 32'd1);
    check("R5 halted still high", {31'd0, halted}, 32'd1);
    @(negedge clk);
    check("R5 halted cleared", {31'd0, halted}, 32'd0);
    writeReg(32'h0000_0001);
    check("R4 run kept while running", {31'd0, runOut}, 32'd1);

    // R6 stop via idle, R4 run ignored while stopping
    writeReg(32'h0000_0000);
    check("R6 run cleared", {31'd0, runOut}, 32'd0);
    repeat (3) @(negedge clk);
    check("R6 halted waits for idle", {31'd0, halted}, 32'd0);
    writeReg(32'h0000_0001);
    check("R4 run ignored while stopping", {31'd0, runOut}, 32'd0);
    engineIdle = 1'b1;
    @(negedge clk);
    check("R6 halted after idle", {31'd0, halted}, 32'd1);
    engineIdle = 1'b0;

    // R7 tick bound
    writeReg(32'h0000_0001);
    repeat (2) @(negedge clk);
    writeReg(32'h0000_0000);
    for (int t = 0; t < 15; t++) tickPulse();
    repeat (3) @(negedge clk);
    check("R7 not halted after 15 ticks", {31'd0, halted}, 32'd0);
    tickPulse();
    check("R7 not halted at 16th tick edge", {31'd0, halted}, 32'd0);
    @(negedge clk);
    check("R7 halted after 16 ticks", {31'd0, halted}, 32'd1);

    // R8 controller reset
    writeReg(32'h0011_0B31);
    @(negedge clk);
    engineIdle = 1'b1;
    writeReg(32'h0011_0B30);
    @(negedge clk);
    engineIdle = 1'b0;
    check("R8 halted before reset", {31'd0, halted}, 32'd1);
    writeReg(32'h0000_0002);
    check("R8 defaults during reset", rdData, 32'h0000_0B02);
    begin
      int n = 0;
      wrEn = 1'b1;
      wrData = 32'h0000_0030;
      while (rdData[1] && n < 100) begin
        n++;
        @(negedge clk);
        wrEn = 1'b0;
        wrData = '0;
      end
      check("R8 reset length", n, RESET_CYCLES);
    end
    check("R8 readback after reset", rdData, 32'h0000_0B00);
    check("R8 halted after reset", {31'd0, halted}, 32'd1);

    // R9 doorbell
    writeReg(32'h0000_0B60);
    check("R9 doorbell set", {31'd0, doorbellOut}, 32'd1);
    writeReg(32'h0000_0B20);
    check("R9 zero write no effect", {31'd0, doorbellOut}, 32'd1);
    @(negedge clk);
    doorbellAck = 1'b1;
    @(negedge clk);
    doorbellAck = 1'b0;
    check("R9 ack clears", {31'd0, doorbellOut}, 32'd0);

    finishRun();
  end
endmodule